// File: doc/BRIEF.md
# Streaming Arbitrary-Ratio Video Downscaler

This block shrinks a raster of pixels, arriving one per valid cycle, to a smaller output raster whose width and height are requested independently. The input size comes from the scaler stage in front of it. The output size is a single 32-bit word. Each axis steps through the input with its own accumulator, so the two ratios need not match and need not be integers. Every output sample covers a rectangular region of input pixels. In nearest mode the output is one chosen pixel of that region. In box mode the output is the mean of the region.

The configuration is taken on the start-of-frame pixel and held for the rest of the frame. If the size request is illegal, the block raises an error flag and produces nothing until a later frame starts with a legal request. If the requested size equals the input size, the block reports pass-through, and its data path then reproduces the input unchanged. A line store keeps one partial result per output column, which carries vertical regions across several input lines. The output line-end and frame-start markers are generated from the block's own output counters.

Top module: `vid_downscale`

## Requirements
- R1: `out_geom[31:16]` is the output width and `out_geom[15:0]` is the output height. A valid frame yields exactly width×height outputs in raster order. `m_sof` marks the first of them and `m_eol` marks the last of each output row.
- R2: When the requested width and height equal `in_w`/`in_h`, `passthru` reads 1 after the start-of-frame pixel, and the output sequence is identical to the input pixels.
- R3: A request with zero width or height, a dimension larger than the input, or a width above `MAX_W` is illegal. After that start-of-frame pixel `cfg_err` reads 1, and no output appears until a frame starts with a legal request.
- R4: With `fmt_422` = 1, an odd requested width is illegal, with the same effect as R3. An even width is accepted.
- R5: Regions per axis: an accumulator starts at 0 at each line (horizontal) or frame (vertical) and adds the output size once per input step. Whenever the total reaches the input size, the step closes a region and the input size is subtracted.
- R6: `filt_mode` = 0 (nearest) outputs the top-left input pixel of each region.
- R7: `filt_mode` = 1 (box) outputs (S·Q(n)) >> 16. S is the region sum, n is the region pixel count, and Q(n) = (65536 + n/2)/n using integer division.
- R8: In box mode, an input size more than `MAX_RATIO` times the output size on either axis is illegal. The same sizes are accepted in nearest mode.
- R9: The reserved codes 2 and 3 of `filt_mode` behave exactly as nearest.
- R10: Size, filter and format inputs are sampled only on the start-of-frame pixel. Changing them during a frame has no effect on that frame.
- R11: After reset `m_valid`, `cfg_err` and `passthru` are 0, and pixels are ignored until a start-of-frame pixel arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_w | input | 16 | Input width from the upstream stage |
| in_h | input | 16 | Input height from the upstream stage |
| out_geom | input | 32 | Requested output width (upper half) and height (lower half) |
| filt_mode | input | 2 | 0 nearest, 1 box, 2/3 reserved (nearest) |
| fmt_422 | input | 1 | Packed 4:2:2 output selected (width must be even) |
| s_valid | input | 1 | Input pixel valid |
| s_sof | input | 1 | First pixel of a frame |
| s_eol | input | 1 | Last pixel of an input line |
| s_data | input | PIX_W | Input pixel |
| m_valid | output | 1 | Output sample valid |
| m_sof | output | 1 | First output sample of the frame |
| m_eol | output | 1 | Last output sample of a row |
| m_data | output | PIX_W | Output sample |
| cfg_err | output | 1 | Latched request for this frame is illegal |
| passthru | output | 1 | Latched request is 1:1 |

## Verification
The bench builds the block with 8-bit pixels and a line store of 32 columns. That makes the `MAX_W` limit reachable: a 33-column request over a 40-pixel input is rejected, and a 32-column output fills every column of the store. `MAX_RATIO` stays at 8, so an 8×8 box region reaches the last reciprocal entry (n = 64), and a 27→3 box request lands just beyond the ratio limit. Frames with idle gaps, a one-line frame and mid-frame changes to the settings exercise the accumulators and the per-frame latching.

// File: rtl/dscale_pkg.sv
package dscale_pkg;

   localparam int GEOM_W     = 16;
   localparam int RECIP_FRAC = 16;

   typedef enum logic [1:0] {
      FILT_NEAREST = 2'd0,
      FILT_BOX     = 2'd1,
      FILT_RSV2    = 2'd2,
      FILT_RSV3    = 2'd3
   } filt_e;

   typedef struct packed {
      logic [GEOM_W-1:0] in_w;
      logic [GEOM_W-1:0] in_h;
      logic [GEOM_W-1:0] out_w;
      logic [GEOM_W-1:0] out_h;
      logic              box;
      logic              ok;
      logic              pass;
   } cfg_t;

endpackage

// File: rtl/dscale_geom_chk.sv
module dscale_geom_chk
   import dscale_pkg::*;
#(
   parameter int MAX_W     = 256,
   parameter int MAX_RATIO = 8
) (
   input  logic [GEOM_W-1:0]   in_w,
   input  logic [GEOM_W-1:0]   in_h,
   input  logic [2*GEOM_W-1:0] out_geom,
   input  logic [1:0]          filt_mode,
   input  logic                fmt_422,
   output cfg_t                cfg
);
   localparam int XW = GEOM_W + $clog2(MAX_RATIO) + 1;

   logic [GEOM_W-1:0] ow, oh;
   logic nonzero, fits, odd_bad, ratio_ok, store_ok, box;

   always_comb begin
      ow       = out_geom[2*GEOM_W-1:GEOM_W];
      oh       = out_geom[GEOM_W-1:0];
      box      = (filt_e'(filt_mode) == FILT_BOX);
      nonzero  = (ow != '0) && (oh != '0);
      fits     = (ow <= in_w) && (oh <= in_h);
      store_ok = (32'(ow) <= MAX_W);
      odd_bad  = fmt_422 && ow[0];
      ratio_ok = (XW'(in_w) <= XW'(ow) * XW'(MAX_RATIO)) &&
                 (XW'(in_h) <= XW'(oh) * XW'(MAX_RATIO));
      cfg.in_w  = in_w;
      cfg.in_h  = in_h;
      cfg.out_w = ow;
      cfg.out_h = oh;
      cfg.box   = box;
      cfg.ok    = nonzero && fits && store_ok && !odd_bad && (!box || ratio_ok);
      cfg.pass  = cfg.ok && (ow == in_w) && (oh == in_h);
   end
endmodule

// File: rtl/dscale_axis.sv
module dscale_axis #(
   parameter int W  = 16,
   parameter int CW = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fresh,
   input  logic         step,
   input  logic [W-1:0] out_sz,
   input  logic [W-1:0] in_sz,
   output logic         hit,
   output logic         first,
   output logic [CW-1:0] cnt
);
   logic [W-1:0]  acc_q, acc_eff;
   logic [CW-1:0] cnt_q, cnt_eff;
   logic [W:0]    sum, nxt;

   always_comb begin
      acc_eff = fresh ? '0 : acc_q;
      cnt_eff = fresh ? '0 : cnt_q;
      sum     = {1'b0, acc_eff} + {1'b0, out_sz};
      hit     = (sum >= {1'b0, in_sz});
      nxt     = hit ? (sum - {1'b0, in_sz}) : sum;
      first   = (cnt_eff == '0);
      cnt     = (&cnt_eff) ? cnt_eff : cnt_eff + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (step) begin
         acc_q <= W'(nxt);
         cnt_q <= hit ? '0 : cnt;
      end else if (fresh) begin
         acc_q <= '0;
         cnt_q <= '0;
      end
   end

   // R5: the carried remainder always stays below the input size
   p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (acc_eff < in_sz) && (out_sz <= in_sz)) |=> (acc_q < $past(in_sz)));
endmodule

// File: rtl/dscale_norm.sv
module dscale_norm #(
   parameter int PIX_W   = 8,
   parameter int SUM_W   = 14,
   parameter int CNT_MAX = 64,
   parameter int NW      = 7,
   parameter int FRAC    = 16
) (
   input  logic [SUM_W-1:0] sum,
   input  logic [NW-1:0]    n,
   output logic [PIX_W-1:0] avg
);
   localparam int PW = SUM_W + FRAC + 1;

   logic [FRAC:0] rtab [CNT_MAX];

   for (genvar i = 0; i < CNT_MAX; i++) begin : g_rcp
      assign rtab[i] = (FRAC+1)'(((2**FRAC) + (i + 1) / 2) / (i + 1));
   end

   logic [NW-1:0] idx;
   logic [FRAC:0] r;
   logic [PW-1:0] prod;

   always_comb begin
      idx  = (n == '0) ? '0 : n - 1'b1;
      r    = rtab[idx];
      prod = PW'(sum) * PW'(r);
      avg  = PIX_W'(prod >> FRAC);
   end
endmodule

// File: rtl/dscale_line.sv
module dscale_line #(
   parameter int DEPTH = 256,
   parameter int DW    = 14,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/vid_downscale.sv
module vid_downscale
   import dscale_pkg::*;
#(
   parameter int PIX_W     = 8,
   parameter int MAX_W     = 256,
   parameter int MAX_RATIO = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [15:0]         in_w,
   input  logic [15:0]         in_h,
   input  logic [31:0]         out_geom,
   input  logic [1:0]          filt_mode,
   input  logic                fmt_422,
   input  logic                s_valid,
   input  logic                s_sof,
   input  logic                s_eol,
   input  logic [PIX_W-1:0]    s_data,
   output logic                m_valid,
   output logic                m_sof,
   output logic                m_eol,
   output logic [PIX_W-1:0]    m_data,
   output logic                cfg_err,
   output logic                passthru
);
   localparam int CNT_MAX = MAX_RATIO * MAX_RATIO;
   localparam int NW      = $clog2(CNT_MAX) + 1;
   localparam int SUM_W   = PIX_W + $clog2(CNT_MAX);
   localparam int AW      = $clog2(MAX_W);
   localparam int CW      = 4;

   if (PIX_W < 1 || PIX_W > 16) begin : g_bad_pix
      $error("PIX_W must lie in 1..16");
   end
   if (MAX_W < 2 || MAX_W > 4096) begin : g_bad_w
      $error("MAX_W must lie in 2..4096");
   end
   if (MAX_RATIO < 2 || MAX_RATIO > 8) begin : g_bad_ratio
      $error("MAX_RATIO must lie in 2..8");
   end

   // configuration: live check, latch on start of frame
   cfg_t cfg_live, cfg_q, cfg;
   logic active_q, run_ok, pv, sof_px;

   dscale_geom_chk #(.MAX_W(MAX_W), .MAX_RATIO(MAX_RATIO)) u_chk (
      .in_w(in_w), .in_h(in_h), .out_geom(out_geom),
      .filt_mode(filt_mode), .fmt_422(fmt_422), .cfg(cfg_live)
   );

   always_comb begin
      sof_px = s_valid && s_sof;
      cfg    = s_sof ? cfg_live : cfg_q;
      run_ok = s_sof ? cfg_live.ok : (active_q && cfg_q.ok);
      pv     = s_valid && run_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         active_q <= 1'b0;
         cfg_err  <= 1'b0;
         passthru <= 1'b0;
      end else if (sof_px) begin
         cfg_q    <= cfg_live;
         active_q <= 1'b1;
         cfg_err  <= !cfg_live.ok;
         passthru <= cfg_live.pass;
      end
   end

   // per-axis stepping
   logic h_hit, h_first, v_hit, v_first;
   logic [CW-1:0] h_cnt, v_cnt;

   dscale_axis #(.W(GEOM_W), .CW(CW)) u_hax (
      .clk(clk), .rst_n(rst_n), .fresh(sof_px), .step(pv),
      .out_sz(cfg.out_w), .in_sz(cfg.in_w),
      .hit(h_hit), .first(h_first), .cnt(h_cnt)
   );

   dscale_axis #(.W(GEOM_W), .CW(CW)) u_vax (
      .clk(clk), .rst_n(rst_n), .fresh(sof_px), .step(pv && s_eol),
      .out_sz(cfg.out_h), .in_sz(cfg.in_h),
      .hit(v_hit), .first(v_first), .cnt(v_cnt)
   );

   // horizontal region gathering
   logic [AW-1:0]    oc_q, oc_eff;
   logic [SUM_W-1:0] hsum_q, hsum_eff, hpick_q, hpick, lb_rd, base;
   logic             lb_we;

   always_comb begin
      oc_eff   = s_sof ? '0 : oc_q;
      hsum_eff = h_first ? SUM_W'(s_data) : hsum_q + SUM_W'(s_data);
      hpick    = h_first ? SUM_W'(s_data) : hpick_q;
      if (cfg.box) base = v_first ? hsum_eff : lb_rd + hsum_eff;
      else         base = v_first ? hpick    : lb_rd;
      lb_we    = pv && h_hit && !v_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oc_q    <= '0;
         hsum_q  <= '0;
         hpick_q <= '0;
      end else begin
         if (pv) begin
            hsum_q  <= hsum_eff;
            hpick_q <= hpick;
            if (s_eol)      oc_q <= '0;
            else if (h_hit) oc_q <= oc_eff + 1'b1;
            else            oc_q <= oc_eff;
         end else if (sof_px) begin
            oc_q <= '0;
         end
      end
   end

   dscale_line #(.DEPTH(MAX_W), .DW(SUM_W), .AW(AW)) u_line (
      .clk(clk), .we(lb_we), .waddr(oc_eff), .wdata(base),
      .raddr(oc_eff), .rdata(lb_rd)
   );

   // normalisation
   logic [2*CW-1:0]  n_raw;
   logic [NW-1:0]    n_sel;
   logic [PIX_W-1:0] avg, out_val;

   always_comb begin
      n_raw = h_cnt * v_cnt;
      n_sel = (32'(n_raw) > CNT_MAX) ? NW'(CNT_MAX) : NW'(n_raw);
   end

   dscale_norm #(.PIX_W(PIX_W), .SUM_W(SUM_W), .CNT_MAX(CNT_MAX), .NW(NW),
                 .FRAC(RECIP_FRAC)) u_norm (
      .sum(base), .n(n_sel), .avg(avg)
   );

   assign out_val = cfg.box ? avg : PIX_W'(base);

   // output counters and registers
   logic [GEOM_W-1:0] ox_q, oy_q, ox_eff, oy_eff;
   logic              emit, row_end;

   always_comb begin
      ox_eff  = s_sof ? '0 : ox_q;
      oy_eff  = s_sof ? '0 : oy_q;
      emit    = pv && h_hit && v_hit;
      row_end = (ox_eff == cfg.out_w - 1'b1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ox_q    <= '0;
         oy_q    <= '0;
         m_valid <= 1'b0;
         m_sof   <= 1'b0;
         m_eol   <= 1'b0;
         m_data  <= '0;
      end else begin
         m_valid <= emit;
         if (emit) begin
            m_data <= out_val;
            m_sof  <= (ox_eff == '0) && (oy_eff == '0);
            m_eol  <= row_end;
            ox_q   <= row_end ? '0 : ox_eff + 1'b1;
            oy_q   <= row_end ? oy_eff + 1'b1 : oy_eff;
         end else if (sof_px) begin
            ox_q <= '0;
            oy_q <= '0;
         end
      end
   end

   // R3: an illegal latched request keeps the output silent
   p_err_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !m_valid);

   // R2: in 1:1 mode each output is the pixel taken the cycle before
   p_pass_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && passthru) |-> (m_data == $past(s_data)));

   // R5: the last pixel of every input line closes a horizontal region
   p_line_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && s_eol) |-> h_hit);

   // R8: box regions never span more than MAX_RATIO pixels per axis
   p_box_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && cfg.box && h_hit) |-> ((32'(h_cnt) <= MAX_RATIO) && (32'(v_cnt) <= MAX_RATIO)));
endmodule

// File: tb/vid_downscale_tb.sv
module vid_downscale_tb;
   localparam int PIX_W = 8;
   localparam int MAX_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] in_w = '0, in_h = '0;
   logic [31:0] out_geom = '0;
   logic [1:0]  filt_mode = '0;
   logic        fmt_422 = 1'b0;
   logic        s_valid = 1'b0, s_sof = 1'b0, s_eol = 1'b0;
   logic [PIX_W-1:0] s_data = '0;
   logic        m_valid, m_sof, m_eol, cfg_err, passthru;
   logic [PIX_W-1:0] m_data;

   always #2 clk = ~clk;

   vid_downscale #(.PIX_W(PIX_W), .MAX_W(MAX_W), .MAX_RATIO(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_w(in_w), .in_h(in_h), .out_geom(out_geom),
      .filt_mode(filt_mode), .fmt_422(fmt_422), .s_valid(s_valid), .s_sof(s_sof),
      .s_eol(s_eol), .s_data(s_data), .m_valid(m_valid), .m_sof(m_sof),
      .m_eol(m_eol), .m_data(m_data), .cfg_err(cfg_err), .passthru(passthru)
   );

   typedef struct {
      int  data;
      bit  sof;
      bit  eol;
   } item_t;

   item_t exp_q[$];
   int    total = 0;
   int    bad = 0;
   int    seen = 0;
   string cur_tag = "R11";

   task automatic check(input bit cond, input string tag, input string what,
                        input int act, input int expv);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   function automatic int pix(input int x, input int y, input int seed);
      return (x * 37 + y * 91 + seed * 53 + ((x * y) % 7) * 11) % 256;
   endfunction

   // monitor: pop and compare on every output sample
   always @(negedge clk) begin
      if (rst_n && m_valid) begin
         seen++;
         if (exp_q.size() == 0) begin
            check(1'b0, cur_tag, "unexpected output sample", int'(m_data), -1);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            check(int'(m_data) == it.data, cur_tag, "data", int'(m_data), it.data);
            check(m_sof == it.sof, "R1", "m_sof", int'(m_sof), int'(it.sof));
            check(m_eol == it.eol, "R1", "m_eol", int'(m_eol), int'(it.eol));
         end
      end
   end

   // regions per axis built with the accumulator rule of R5
   task automatic regions(input int isz, input int osz, output int st[256], output int ln[256]);
      int acc = 0;
      int cnt = 0;
      int k = 0;
      for (int i = 0; i < isz; i++) begin
         if (cnt == 0) st[k] = i;
         cnt++;
         acc += osz;
         if (acc >= isz) begin
            acc -= isz;
            ln[k] = cnt;
            k++;
            cnt = 0;
         end
      end
   endtask

   task automatic send_frame(input string tag, input int iw, input int ih,
                             input int ow, input int oh, input int mode,
                             input bit f422, input bit exp_ok, input bit gaps,
                             input bit chg_mid, input int seed);
      int hs[256], hl[256], vs[256], vl[256];
      int exp_cnt;
      cur_tag = tag;
      @(negedge clk);
      in_w      = 16'(iw);
      in_h      = 16'(ih);
      out_geom  = {16'(ow), 16'(oh)};
      filt_mode = 2'(mode);
      fmt_422   = f422;
      seen      = 0;
      exp_cnt   = 0;
      if (exp_ok) begin
         regions(iw, ow, hs, hl);
         regions(ih, oh, vs, vl);
         for (int j = 0; j < oh; j++) begin
            for (int i = 0; i < ow; i++) begin
               item_t it;
               if (mode == 1) begin
                  longint sum = 0;
                  int n = hl[i] * vl[j];
                  longint q = (65536 + n / 2) / n;
                  for (int y = vs[j]; y < vs[j] + vl[j]; y++)
                     for (int x = hs[i]; x < hs[i] + hl[i]; x++)
                        sum += pix(x, y, seed);
                  it.data = int'((sum * q) >>> 16);
               end else begin
                  it.data = pix(hs[i], vs[j], seed);
               end
               it.sof = (i == 0) && (j == 0);
               it.eol = (i == ow - 1);
               exp_q.push_back(it);
               exp_cnt++;
            end
         end
      end
      for (int y = 0; y < ih; y++) begin
         for (int x = 0; x < iw; x++) begin
            if (gaps && ((x + y) % 3 == 1)) begin
               s_valid = 1'b0;
               @(negedge clk);
            end
            s_valid = 1'b1;
            s_sof   = (x == 0) && (y == 0);
            s_eol   = (x == iw - 1);
            s_data  = PIX_W'(pix(x, y, seed));
            @(negedge clk);
            if (chg_mid && x == 0 && y == 0) begin
               out_geom  = {16'd3, 16'd1};
               filt_mode = (mode == 1) ? 2'd0 : 2'd1;
               in_w      = 16'(iw + 5);
            end
         end
      end
      s_valid = 1'b0;
      s_sof   = 1'b0;
      s_eol   = 1'b0;
      repeat (3) @(negedge clk);
      check(cfg_err == !exp_ok, (exp_ok ? tag : tag), "cfg_err", int'(cfg_err), int'(!exp_ok));
      check(passthru == (exp_ok && iw == ow && ih == oh), "R2", "passthru flag",
            int'(passthru), int'(exp_ok && iw == ow && ih == oh));
      check(seen == exp_cnt, "R1", "output count", seen, exp_cnt);
      check(exp_q.size() == 0, tag, "samples still expected", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state and pixels without a frame start are ignored
      check(m_valid == 1'b0, "R11", "m_valid after reset", int'(m_valid), 0);
      check(cfg_err == 1'b0, "R11", "cfg_err after reset", int'(cfg_err), 0);
      check(passthru == 1'b0, "R11", "passthru after reset", int'(passthru), 0);
      in_w = 16'd4; in_h = 16'd2; out_geom = {16'd4, 16'd2};
      for (int k = 0; k < 6; k++) begin
         s_valid = 1'b1; s_sof = 1'b0; s_eol = (k % 4 == 3); s_data = 8'(k);
         @(negedge clk);
         check(m_valid == 1'b0, "R11", "output before frame start", int'(m_valid), 0);
      end
      s_valid = 1'b0; s_eol = 1'b0;
      @(negedge clk);

      // R2: 1:1 in nearest and box
      send_frame("R2", 8, 4, 8, 4, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1);
      send_frame("R2", 8, 4, 8, 4, 1, 1'b0, 1'b1, 1'b1, 1'b0, 2);
      // R5 R6: nearest, non-integer ratios
      send_frame("R6", 20, 10, 7, 4, 0, 1'b0, 1'b1, 1'b0, 1'b0, 3);
      send_frame("R5", 13, 7, 5, 3, 0, 1'b0, 1'b1, 1'b1, 1'b0, 4);
      // R7: box averaging, including a single 8x8 region (n = 64)
      send_frame("R7", 24, 9, 5, 3, 1, 1'b0, 1'b1, 1'b1, 1'b0, 5);
      send_frame("R7", 8, 8, 1, 1, 1, 1'b0, 1'b1, 1'b0, 1'b0, 6);
      send_frame("R7", 17, 1, 6, 1, 1, 1'b0, 1'b1, 1'b0, 1'b0, 7);
      // R9: reserved filter codes act as nearest
      send_frame("R9", 16, 8, 6, 3, 2, 1'b0, 1'b1, 1'b0, 1'b0, 8);
      send_frame("R9", 16, 8, 6, 3, 3, 1'b0, 1'b1, 1'b0, 1'b0, 9);
      // R3: illegal requests, then recovery
      send_frame("R3", 10, 4, 0, 2, 0, 1'b0, 1'b0, 1'b0, 1'b0, 10);
      send_frame("R3", 10, 4, 11, 2, 0, 1'b0, 1'b0, 1'b0, 1'b0, 11);
      send_frame("R3", 10, 4, 5, 5, 0, 1'b0, 1'b0, 1'b0, 1'b0, 12);
      send_frame("R3", 40, 2, 33, 2, 0, 1'b0, 1'b0, 1'b0, 1'b0, 13);
      send_frame("R3", 40, 2, 32, 2, 0, 1'b0, 1'b1, 1'b0, 1'b0, 14);
      // R4: odd width refused for 4:2:2, even width accepted
      send_frame("R4", 16, 4, 5, 2, 0, 1'b1, 1'b0, 1'b0, 1'b0, 15);
      send_frame("R4", 16, 4, 6, 2, 0, 1'b1, 1'b1, 1'b0, 1'b0, 16);
      // R8: box ratio above 8 refused, nearest accepts it
      send_frame("R8", 27, 4, 3, 2, 1, 1'b0, 1'b0, 1'b0, 1'b0, 17);
      send_frame("R8", 27, 4, 3, 2, 0, 1'b0, 1'b1, 1'b0, 1'b0, 18);
      send_frame("R8", 24, 16, 3, 2, 1, 1'b0, 1'b1, 1'b0, 1'b0, 19);
      // R10: settings changed after the start-of-frame pixel are ignored
      send_frame("R10", 18, 6, 7, 4, 1, 1'b0, 1'b1, 1'b1, 1'b1, 20);
      send_frame("R10", 12, 5, 5, 2, 0, 1'b0, 1'b1, 1'b0, 1'b1, 21);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule